// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block is the host-side sequencer that programs a 7-bit step attenuator. A request carries a 7-bit attenuation code and a mode choice. In serial mode the block shifts the code out on a 3-wire link made of a serial clock, a data line and a latch strobe. The most significant bit goes first. After the last bit it pulses the latch. In parallel mode it drives the code onto a 7-bit bus and pulses the same latch line. This is a latched transfer, and the device captures the bus on the strobe.

Every interval is a parameter counted in system-clock cycles. These intervals are the clock low and high phases, the latch setup, the latch width, the spacing after the latch and the parallel setup. The integrator picks values that meet the device minimums at the chosen system clock. With a 10 ns clock the defaults give:

- an 80 ns serial period,
- 40 ns of data setup and 40 ns of data hold,
- a 10 ns latch pulse,
- 630 ns of spacing before another latch pulse can occur.

A busy flag covers the whole transfer, including the spacing. A one-cycle done pulse marks its end.

Top module: `atten_prog_master`

## Requirements
- R1: After reset, and whenever busy is low, ser_clk, ser_data and latch_en are 0. After reset, busy, done, mode_sel and par_data are also 0.
- R2: A request (req_valid high) is taken only while busy is low. A request raised while busy is high changes neither the transfer in progress nor mode_sel nor par_data, and it starts no later transfer.
- R3: A serial request (req_serial=1) drives mode_sel to 1. It produces exactly 7 rising ser_clk edges, and ser_data carries req_code bit 6 down to bit 0 at those edges.
- R4: Each serial bit occupies CLK_LO_CYC cycles with ser_clk low, then CLK_HI_CYC cycles with ser_clk high. The first bit's low phase begins in the cycle after acceptance. ser_data holds its bit for the full low and high phases, and it is 0 outside the shifting window.
- R5: latch_en stays low while bits are shifted. It rises LE_SETUP_CYC cycles after ser_clk falls for the last time. ser_clk is never high together with latch_en.
- R6: latch_en stays high for exactly LE_WIDTH_CYC cycles per transfer.
- R7: busy rises in the cycle after acceptance and stays high until LE_GAP_CYC cycles after latch_en falls. done is high for exactly the one cycle in which busy has just fallen.
- R8: A parallel request (req_serial=0) drives mode_sel to 0 and par_data to req_code from the cycle after acceptance. latch_en rises after PAR_SETUP_CYC cycles, and ser_clk and ser_data stay 0 throughout.
- R9: par_data changes only when a parallel request is accepted. It holds through the latch pulse, the spacing, later idle time and serial transfers.
- R10: A request presented in the cycle where done is high is accepted at once, so back-to-back transfers need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_serial | input | 1 | 1 selects a serial write, 0 a latched parallel write |
| req_code | input | 7 | Attenuation code to program |
| busy | output | 1 | Transfer or post-latch spacing in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ser_clk | output | 1 | Serial shift clock to the device |
| ser_data | output | 1 | Serial data to the device |
| latch_en | output | 1 | Latch strobe to the device |
| mode_sel | output | 1 | Device mode pin: 1 serial, 0 parallel |
| par_data | output | 7 | Parallel code bus to the device |

## Verification
The hardest situations to reach from the ports are a request arriving in the middle of a transfer and a request arriving in the exact cycle done is high. Reaching either needs stimulus aligned to an internal phase the bench cannot see directly. The bench tracks the cycle count from acceptance and compares every output against a cycle-exact timeline built from the interval parameters. From that count it injects a conflicting opposite-mode request partway through a serial shift, and it raises the next request on the done sample itself. Non-default intervals with unequal clock phases expose any swapped or off-by-one phase length.

// File: rtl/atp_pkg.sv
package atp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_LE_SETUP,
        ST_PAR_SETUP,
        ST_LE_HIGH,
        ST_GAP
    } atp_state_e;

    function automatic int atp_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atp_timer.sv
module atp_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/atp_shifter.sv
module atp_shifter #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             msb
);

    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = load_val;
        end else if (shift) begin
            sh_d = {sh_q[WIDTH-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[WIDTH-1];

endmodule

// File: rtl/atten_prog_master.sv
module atten_prog_master
    import atp_pkg::*;
#(
    parameter int CODE_W        = 7,
    parameter int CLK_LO_CYC    = 4,
    parameter int CLK_HI_CYC    = 4,
    parameter int LE_SETUP_CYC  = 2,
    parameter int LE_WIDTH_CYC  = 1,
    parameter int LE_GAP_CYC    = 63,
    parameter int PAR_SETUP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_serial,
    input  logic [CODE_W-1:0] req_code,
    output logic              busy,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              latch_en,
    output logic              mode_sel,
    output logic [CODE_W-1:0] par_data
);

    localparam int MAX_LEN = atp_max(atp_max(atp_max(CLK_LO_CYC, CLK_HI_CYC),
                                             atp_max(LE_SETUP_CYC, LE_WIDTH_CYC)),
                                     atp_max(LE_GAP_CYC, PAR_SETUP_CYC));
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

    localparam logic [CNT_W-1:0] LO_LD  = CNT_W'(CLK_LO_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LD  = CNT_W'(CLK_HI_CYC - 1);
    localparam logic [CNT_W-1:0] LS_LD  = CNT_W'(LE_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LW_LD  = CNT_W'(LE_WIDTH_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(LE_GAP_CYC - 1);
    localparam logic [CNT_W-1:0] PS_LD  = CNT_W'(PAR_SETUP_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CODE_W - 1);

    typedef struct packed {
        atp_state_e        state;
        logic [BIT_W-1:0]  bit_idx;
        logic              ser_clk;
        logic              latch_en;
        logic              mode_sel;
        logic [CODE_W-1:0] par_data;
        logic              busy;
        logic              done;
    } atp_regs_t;

    atp_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_msb;

    atp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    atp_shifter #(.WIDTH(CODE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (req_code),
        .shift    (sh_shift),
        .msb      (sh_msb)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.busy = 1'b1;
                    tmr_load = 1'b1;
                    if (req_serial) begin
                        r_d.state    = ST_SHIFT_LO;
                        r_d.mode_sel = 1'b1;
                        r_d.bit_idx  = '0;
                        sh_load      = 1'b1;
                        tmr_val      = LO_LD;
                    end else begin
                        r_d.state    = ST_PAR_SETUP;
                        r_d.mode_sel = 1'b0;
                        r_d.par_data = req_code;
                        tmr_val      = PS_LD;
                    end
                end
            end
            ST_SHIFT_LO: begin
                if (tmr_exp) begin
                    r_d.state = ST_SHIFT_HI;
                    tmr_load  = 1'b1;
                    tmr_val   = HI_LD;
                end
            end
            ST_SHIFT_HI: begin
                if (tmr_exp) begin
                    sh_shift = 1'b1;
                    tmr_load = 1'b1;
                    if (r_q.bit_idx == LAST_BIT) begin
                        r_d.state = ST_LE_SETUP;
                        tmr_val   = LS_LD;
                    end else begin
                        r_d.state   = ST_SHIFT_LO;
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        tmr_val     = LO_LD;
                    end
                end
            end
            ST_LE_SETUP, ST_PAR_SETUP: begin
                if (tmr_exp) begin
                    r_d.state = ST_LE_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = LW_LD;
                end
            end
            ST_LE_HIGH: begin
                if (tmr_exp) begin
                    r_d.state = ST_GAP;
                    tmr_load  = 1'b1;
                    tmr_val   = GAP_LD;
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    r_d.state = ST_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.busy  = 1'b0;
            end
        endcase

        r_d.ser_clk  = (r_d.state == ST_SHIFT_HI);
        r_d.latch_en = (r_d.state == ST_LE_HIGH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, bit_idx: '0, ser_clk: 1'b0, latch_en: 1'b0,
                     mode_sel: 1'b0, par_data: '0, busy: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign ser_clk  = r_q.ser_clk;
    assign ser_data = sh_msb;
    assign latch_en = r_q.latch_en;
    assign mode_sel = r_q.mode_sel;
    assign par_data = r_q.par_data;

endmodule

// File: rtl/atp_checker.sv
module atp_checker #(
    parameter int CODE_W       = 7,
    parameter int LE_WIDTH_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              ser_clk,
    input logic              ser_data,
    input logic              latch_en,
    input logic              mode_sel,
    input logic [CODE_W-1:0] par_data
);

    int le_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        le_len_q <= 0;
        else if (latch_en) le_len_q <= le_len_q + 1;
        else               le_len_q <= 0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_data && !latch_en));

    a_r5_le_clk_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_clk && latch_en));

    a_r3_clk_serial_only: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> mode_sel);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r2_mode_at_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != $past(mode_sel)) |-> $rose(busy));

    a_r9_par_at_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (par_data != $past(par_data)) |-> ($rose(busy) && !mode_sel));

    a_r6_le_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_en) |-> (le_len_q == LE_WIDTH_CYC));

endmodule

bind atten_prog_master atp_checker #(
    .CODE_W       (CODE_W),
    .LE_WIDTH_CYC (LE_WIDTH_CYC)
) u_atp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .latch_en (latch_en),
    .mode_sel (mode_sel),
    .par_data (par_data)
);

// File: tb/atten_prog_master_tb_top.sv
module atten_prog_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LO  = 3;
    localparam int HI  = 5;
    localparam int LS  = 2;
    localparam int LW  = 3;
    localparam int GAP = 20;
    localparam int PS  = 4;
    localparam int P   = LO + HI;
    localparam int SH  = 7 * P;
    localparam int TS  = SH + LS + LW + GAP;
    localparam int TP  = PS + LW + GAP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_serial = 1'b0;
    logic [6:0] req_code = '0;
    logic       busy, done, ser_clk, ser_data, latch_en, mode_sel;
    logic [6:0] par_data;

    int total_cnt = 0;
    int bad_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atten_prog_master #(
        .CODE_W(7), .CLK_LO_CYC(LO), .CLK_HI_CYC(HI), .LE_SETUP_CYC(LS),
        .LE_WIDTH_CYC(LW), .LE_GAP_CYC(GAP), .PAR_SETUP_CYC(PS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_serial(req_serial),
        .req_code(req_code), .busy(busy), .done(done), .ser_clk(ser_clk),
        .ser_data(ser_data), .latch_en(latch_en), .mode_sel(mode_sel),
        .par_data(par_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Called at a negedge; request accepted at the next posedge; returns at the done sample.
    task automatic xfer(input bit ser, input logic [6:0] code, input int inj_k,
                        input logic [6:0] par_prev, output int nerr);
        int total = ser ? TS : TP;
        int bad0 = bad_cnt;
        int rises = 0;
        logic [6:0] cap = '0;
        logic prev_clk = 1'b0;
        req_valid = 1'b1; req_serial = ser; req_code = code;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_code = ~code;
        for (int k = 0; k <= total; k++) begin
            logic e_clk, e_dat, e_le;
            e_clk = 1'b0; e_dat = 1'b0; e_le = 1'b0;
            if (ser) begin
                if (k < SH) begin
                    e_clk = ((k % P) >= LO);
                    e_dat = code[6 - k / P];
                end else if (k >= SH + LS && k < SH + LS + LW) begin
                    e_le = 1'b1;
                end
                chk(ser_clk == e_clk, "R4", ser_clk, e_clk);
                chk(ser_data == e_dat, "R4", ser_data, e_dat);
                if (k >= SH + LS && k < SH + LS + LW) chk(latch_en == e_le, "R6", latch_en, e_le);
                else chk(latch_en == e_le, "R5", latch_en, e_le);
                chk(mode_sel == 1'b1, "R3", mode_sel, 1);
                chk(par_data == par_prev, "R9", par_data, par_prev);
                if (ser_clk && !prev_clk) begin
                    rises++;
                    cap = {cap[5:0], ser_data};
                end
                prev_clk = ser_clk;
            end else begin
                e_le = (k >= PS && k < PS + LW);
                chk(latch_en == e_le, "R8", latch_en, e_le);
                chk(ser_clk == 1'b0 && ser_data == 1'b0, "R8", {ser_clk, ser_data}, 0);
                chk(mode_sel == 1'b0, "R8", mode_sel, 0);
                chk(par_data == code, "R8", par_data, code);
            end
            chk(busy == (k < total), "R7", busy, k < total);
            chk(done == (k == total), "R7", done, k == total);
            if (k == inj_k) begin
                req_valid = 1'b1; req_serial = ~ser; req_code = code ^ 7'h55;
            end else begin
                req_valid = 1'b0;
            end
            if (k < total) @(negedge clk);
        end
        req_valid = 1'b0;
        if (ser) begin
            chk(cap == code, "R3", cap, code);
            chk(rises == 7, "R3", rises, 7);
        end
        nerr = bad_cnt - bad0;
    endtask

    task automatic idle_cycles(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!busy && !done, req, {busy, done}, 0);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy, done, ser_clk, ser_data, latch_en, mode_sel} == 6'b0, "R1",
            {busy, done, ser_clk, ser_data, latch_en, mode_sel}, 0);
        chk(par_data == 7'h00, "R1", par_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !ser_clk && !latch_en, "R1", {busy, ser_clk, latch_en}, 0);
    endtask

    task automatic t_serial_patterns;
        int n;
        xfer(1'b1, 7'h5A, -1, 7'h00, n);
        idle_cycles(2, "R1");
        xfer(1'b1, 7'h7F, -1, 7'h00, n);
        idle_cycles(1, "R1");
        xfer(1'b1, 7'h01, -1, 7'h00, n);
        idle_cycles(1, "R1");
    endtask

    task automatic t_parallel_then_serial;
        int n;
        xfer(1'b0, 7'h33, -1, 7'h00, n);
        idle_cycles(3, "R9");
        chk(par_data == 7'h33, "R9", par_data, 7'h33);
        xfer(1'b1, 7'h40, -1, 7'h33, n);
        @(negedge clk);
        chk(par_data == 7'h33, "R9", par_data, 7'h33);
    endtask

    task automatic t_busy_ignore;
        int n;
        xfer(1'b1, 7'h2C, 10, 7'h33, n);
        chk(n == 0, "R2", n, 0);
        idle_cycles(5, "R2");
        chk(par_data == 7'h33 && mode_sel == 1'b1, "R2", {mode_sel, par_data}, {1'b1, 7'h33});
        xfer(1'b0, 7'h0F, PS + 1, 7'h33, n);
        chk(n == 0, "R2", n, 0);
        idle_cycles(3, "R2");
        chk(par_data == 7'h0F && mode_sel == 1'b0, "R2", {mode_sel, par_data}, {1'b0, 7'h0F});
    endtask

    task automatic t_back_to_back;
        int n1, n2, n3;
        xfer(1'b0, 7'h11, -1, 7'h0F, n1);
        xfer(1'b1, 7'h6B, -1, 7'h11, n2);
        xfer(1'b0, 7'h22, -1, 7'h11, n3);
        chk(n2 == 0 && n3 == 0, "R10", n2 + n3, 0);
        idle_cycles(2, "R10");
    endtask

    initial begin
        t_reset();
        t_serial_patterns();
        t_parallel_then_serial();
        t_busy_ignore();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total_cnt++;
            bad_cnt++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
            $finish;
        end
    end

endmodule